// File: doc/BRIEF.md
# Filtered Quadrature Position Decoder

This block turns the raw A, B and index lines of one incremental encoder channel into a signed position count. The system clock is divided down to a sample enable at a programmable rate. On each sample enable every line moves through its own three-stage shift register. A two-of-three majority vote over those stages removes any level change that is only one sample period wide. A larger divider setting gives a lower sample rate and a longer noise window. A smaller setting gives a higher maximum count rate.

The filtered A/B pair drives a four-state phase machine with the states PH_00, PH_10, PH_11 and PH_01, each named after its {A,B} level. On each decode cycle the machine compares the new filtered pair with its current state and takes one of four moves. MV_UP is one step forward, MV_DOWN is one step back, MV_HOLD means no change, and MV_FAULT means both lines changed together. A fault cannot be recovered. It leaves the counter alone, sets a sticky error flag and moves the machine to the new pair. On each rising edge of the filtered index line the counter is copied into a capture register. Software can then check the counts per revolution.

Top module: `qdec_channel`

## Requirements
- R1: A synchronous active-high reset clears the counter, the capture register and the error flag to zero.
- R2: A divider setting N gives one sample enable every N+1 system clocks. With N=3, a step on A changes the count no earlier than the 9th and no later than the 13th clock edge after it is applied.
- R3: A level change on A or on index that lasts only one sample period has no effect on the count, the capture register or the error flag.
- R4: A filtered line takes its new level two sample enables after the enable that first sampled it. The counter moves on the next clock. With N=0, a step applied before edge 1 changes the count at edge 4 and not at edge 3.
- R5: In the {A,B} order 00, 10, 11, 01, 00, each step increases the counter by exactly one (A leading B counts up).
- R6: In the reverse order 00, 01, 11, 10, 00, each step decreases the counter by exactly one.
- R7: A change of both filtered A and filtered B in the same sample period leaves the counter unchanged and sets the error flag. The flag stays set until it is cleared.
- R8: A one-clock pulse on the clear input resets the error flag. If a new error and a clear arrive in the same cycle, the flag stays set.
- R9: A rising edge of the filtered index line copies the current counter value into the capture register. The capture register changes at no other time.
- R10: The counter is 32-bit two's complement and wraps silently. One down step from zero gives 32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | DIV_W (8) | Sample divider setting N, one enable every N+1 clocks |
| enc_a | input | 1 | Raw encoder A line |
| enc_b | input | 1 | Raw encoder B line |
| enc_idx | input | 1 | Raw encoder index line |
| err_clr | input | 1 | Clears the sticky count-error flag |
| count | output | COUNT_W (32) | Signed position count |
| capture | output | COUNT_W (32) | Count captured on the last index rising edge |
| count_err | output | 1 | Sticky flag for a simultaneous A/B change |

## Verification
The checker assumes reset is asserted long enough to load the divider and the filter with known values. It also assumes that, outside faults, the raw lines never move faster than the sample rate can resolve, so the counter moves at most one per decode cycle. The bench drives the lines only at falling clock edges. It holds every intended step for at least eight sample periods, so every real edge passes the filter and is decoded. Glitches are kept to exactly one sample period, and the only simultaneous change is the single deliberate A/B step that should set the error.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    // Phase state named after the filtered {A,B} level it represents
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_t;

    // Decoded move for one decode cycle
    typedef enum logic [1:0] {
        MV_HOLD  = 2'b00,
        MV_UP    = 2'b01,
        MV_DOWN  = 2'b10,
        MV_FAULT = 2'b11
    } move_t;

    function automatic phase_t to_phase(input logic a, input logic b);
        return phase_t'({a, b});
    endfunction

endpackage

// File: rtl/qdec_tick_gen.sv
module qdec_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim_q;

    // the limit is reloaded only at rollover so a new setting waits its turn
    assign tick = (cnt_q >= lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
            lim_q <= div_sel;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/qdec_vote_filter.sv
module qdec_vote_filter #(
    parameter int LINES  = 3,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] filt
);
    localparam int MAJ = STAGES / 2 + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] sh_q;
        logic              vote;

        always_comb begin
            int ones;
            ones = 0;
            for (int k = 0; k < STAGES; k++) begin
                ones = ones + int'(sh_q[k]);
            end
            vote = (ones >= MAJ);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q    <= '0;
                filt[g] <= 1'b0;
            end else if (tick) begin
                sh_q    <= {sh_q[STAGES-2:0], raw[g]};
                filt[g] <= vote;
            end
        end
    end
endmodule

// File: rtl/qdec_phase_fsm.sv
module qdec_phase_fsm
    import qdec_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      dec_en,
    input  logic                      fa,
    input  logic                      fb,
    input  logic                      fidx,
    input  logic                      err_clr,
    output logic signed [COUNT_W-1:0] count,
    output logic signed [COUNT_W-1:0] capture,
    output logic                      count_err,
    output logic                      err_evt,
    output logic                      idx_evt
);
    phase_t state_q;
    phase_t state_d;
    move_t  move;
    logic   idx_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_00;
        end else if (dec_en) begin
            state_q <= state_d;
        end
    end

    // transition decode: forward order is 00 -> 10 -> 11 -> 01 -> 00
    always_comb begin
        state_d = to_phase(fa, fb);
        move    = MV_HOLD;
        unique case (state_q)
            PH_00: begin
                case (state_d)
                    PH_10:   move = MV_UP;
                    PH_01:   move = MV_DOWN;
                    PH_11:   move = MV_FAULT;
                    default: move = MV_HOLD;
                endcase
            end
            PH_10: begin
                case (state_d)
                    PH_11:   move = MV_UP;
                    PH_00:   move = MV_DOWN;
                    PH_01:   move = MV_FAULT;
                    default: move = MV_HOLD;
                endcase
            end
            PH_11: begin
                case (state_d)
                    PH_01:   move = MV_UP;
                    PH_10:   move = MV_DOWN;
                    PH_00:   move = MV_FAULT;
                    default: move = MV_HOLD;
                endcase
            end
            PH_01: begin
                case (state_d)
                    PH_00:   move = MV_UP;
                    PH_11:   move = MV_DOWN;
                    PH_10:   move = MV_FAULT;
                    default: move = MV_HOLD;
                endcase
            end
        endcase
    end

    assign err_evt = dec_en && (move == MV_FAULT);
    assign idx_evt = dec_en && fidx && !idx_q;

    // outputs: counter, capture, sticky error
    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            capture   <= '0;
            count_err <= 1'b0;
            idx_q     <= 1'b0;
        end else begin
            if (dec_en) begin
                idx_q <= fidx;
                if (move == MV_UP) begin
                    count <= count + 1'b1;
                end else if (move == MV_DOWN) begin
                    count <= count - 1'b1;
                end
            end
            if (idx_evt) begin
                capture <= count;
            end
            if (err_evt) begin
                count_err <= 1'b1;
            end else if (err_clr) begin
                count_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/qdec_channel.sv
module qdec_channel #(
    parameter int COUNT_W = 32,
    parameter int DIV_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DIV_W-1:0]          div_sel,
    input  logic                      enc_a,
    input  logic                      enc_b,
    input  logic                      enc_idx,
    input  logic                      err_clr,
    output logic signed [COUNT_W-1:0] count,
    output logic signed [COUNT_W-1:0] capture,
    output logic                      count_err
);
    localparam int LINES = 3;

    logic             tick;
    logic             dec_en;
    logic [LINES-1:0] filt;
    logic             err_evt;
    logic             idx_evt;

    qdec_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .tick    (tick)
    );

    qdec_vote_filter #(.LINES(LINES), .STAGES(3)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .raw  ({enc_idx, enc_b, enc_a}),
        .filt (filt)
    );

    // decode runs one clock after each sample, on freshly voted lines
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_en <= 1'b0;
        end else begin
            dec_en <= tick;
        end
    end

    qdec_phase_fsm #(.COUNT_W(COUNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .dec_en    (dec_en),
        .fa        (filt[0]),
        .fb        (filt[1]),
        .fidx      (filt[2]),
        .err_clr   (err_clr),
        .count     (count),
        .capture   (capture),
        .count_err (count_err),
        .err_evt   (err_evt),
        .idx_evt   (idx_evt)
    );
endmodule

// File: rtl/qdec_channel_chk.sv
module qdec_channel_chk #(
    parameter int COUNT_W = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      dec_en,
    input logic                      err_evt,
    input logic                      idx_evt,
    input logic                      err_clr,
    input logic signed [COUNT_W-1:0] count,
    input logic signed [COUNT_W-1:0] capture,
    input logic                      count_err
);
    // R4
    count_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_en |=> $stable(count));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        dec_en |=> (count == $past(count)
                    || count == $past(count) + 1
                    || count == $past(count) - 1));

    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> ($stable(count) && count_err));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (count_err && !err_clr) |=> count_err);

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !err_evt) |=> !count_err);

    // R9
    capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !idx_evt |=> $stable(capture));

    // R9
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        idx_evt |=> (capture == $past(count)));
endmodule

bind qdec_channel qdec_channel_chk #(.COUNT_W(COUNT_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .dec_en    (dec_en),
    .err_evt   (err_evt),
    .idx_evt   (idx_evt),
    .err_clr   (err_clr),
    .count     (count),
    .capture   (capture),
    .count_err (count_err)
);

// File: tb/test_qdec_channel.sv
`timescale 1ns/1ps
module test_qdec_channel;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [7:0]         div_sel = '0;
    logic               enc_a = 1'b0;
    logic               enc_b = 1'b0;
    logic               enc_idx = 1'b0;
    logic               err_clr = 1'b0;
    logic signed [31:0] count;
    logic signed [31:0] capture;
    logic               count_err;

    int checks = 0;
    int failures = 0;
    logic signed [31:0] exp_cnt = 0;
    logic signed [31:0] exp_cap = 0;

    always #5 clk = ~clk;

    qdec_channel i_qdec_channel (
        .clk       (clk),
        .rst       (rst),
        .div_sel   (div_sel),
        .enc_a     (enc_a),
        .enc_b     (enc_b),
        .enc_idx   (enc_idx),
        .err_clr   (err_clr),
        .count     (count),
        .capture   (capture),
        .count_err (count_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic step_to(input logic a, input logic b);
        @(negedge clk);
        enc_a = a;
        enc_b = b;
        wait_clk(8);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        wait_clk(4);
        @(negedge clk);
        rst = 1'b0;
        wait_clk(2);
        chk("R1 count", count, 32'd0);
        chk("R1 capture", capture, 32'd0);
        chk("R1 err", {31'd0, count_err}, 32'd0);
    endtask

    task automatic t_wrap;
        step_to(1'b0, 1'b1);
        exp_cnt = exp_cnt - 1;
        chk("R10 wrap below zero", count, 32'hFFFF_FFFF);
        step_to(1'b0, 1'b0);
        exp_cnt = exp_cnt + 1;
        chk("R10 back to zero", count, exp_cnt);
    endtask

    task automatic t_latency;
        @(negedge clk);
        enc_a = 1'b1;
        wait_clk(3);
        chk("R4 no change at edge 3", count, exp_cnt);
        wait_clk(1);
        exp_cnt = exp_cnt + 1;
        chk("R4 change at edge 4", count, exp_cnt);
        step_to(1'b0, 1'b0);
        exp_cnt = exp_cnt - 1;
    endtask

    task automatic t_forward;
        for (int r = 0; r < 2; r++) begin
            step_to(1'b1, 1'b0);
            step_to(1'b1, 1'b1);
            step_to(1'b0, 1'b1);
            step_to(1'b0, 1'b0);
            exp_cnt = exp_cnt + 4;
        end
        chk("R5 forward cycles", count, exp_cnt);
        step_to(1'b1, 1'b0);
        exp_cnt = exp_cnt + 1;
        chk("R5 single forward step", count, exp_cnt);
        step_to(1'b0, 1'b0);
        exp_cnt = exp_cnt - 1;
    endtask

    task automatic t_reverse;
        step_to(1'b0, 1'b1);
        step_to(1'b1, 1'b1);
        chk("R6 two reverse steps", count, exp_cnt - 2);
        step_to(1'b1, 1'b0);
        step_to(1'b0, 1'b0);
        exp_cnt = exp_cnt - 4;
        chk("R6 reverse cycle", count, exp_cnt);
    endtask

    task automatic t_glitch;
        @(negedge clk);
        enc_a = 1'b1;
        @(negedge clk);
        enc_a = 1'b0;
        wait_clk(10);
        chk("R3 A glitch count", count, exp_cnt);
        chk("R3 A glitch err", {31'd0, count_err}, 32'd0);
    endtask

    task automatic t_index;
        @(negedge clk);
        enc_idx = 1'b1;
        wait_clk(8);
        @(negedge clk);
        enc_idx = 1'b0;
        wait_clk(8);
        exp_cap = exp_cnt;
        chk("R9 index capture", capture, exp_cap);
        step_to(1'b1, 1'b0);
        exp_cnt = exp_cnt + 1;
        @(negedge clk);
        enc_idx = 1'b1;
        @(negedge clk);
        enc_idx = 1'b0;
        wait_clk(10);
        chk("R3 index glitch no capture", capture, exp_cap);
        step_to(1'b0, 1'b0);
        exp_cnt = exp_cnt - 1;
    endtask

    task automatic t_error;
        step_to(1'b1, 1'b1);
        chk("R7 fault holds count", count, exp_cnt);
        chk("R7 fault sets err", {31'd0, count_err}, 32'd1);
        step_to(1'b0, 1'b1);
        exp_cnt = exp_cnt + 1;
        chk("R7 err sticky", {31'd0, count_err}, 32'd1);
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        wait_clk(2);
        chk("R8 clear", {31'd0, count_err}, 32'd0);
        step_to(1'b0, 1'b0);
        exp_cnt = exp_cnt + 1;
        chk("R7 count after fault", count, exp_cnt);
    endtask

    task automatic t_divider;
        @(negedge clk);
        div_sel = 8'd3;
        wait_clk(12);
        @(negedge clk);
        enc_a = 1'b1;
        wait_clk(8);
        chk("R2 slow sample no early change", count, exp_cnt);
        wait_clk(5);
        exp_cnt = exp_cnt + 1;
        chk("R2 slow sample change", count, exp_cnt);
        @(negedge clk);
        enc_a = 1'b0;
        repeat (3) @(negedge clk);
        enc_a = 1'b1;
        wait_clk(30);
        chk("R3 one slow period glitch", count, exp_cnt);
        @(negedge clk);
        enc_a = 1'b0;
        wait_clk(30);
        exp_cnt = exp_cnt - 1;
        chk("R2 return step", count, exp_cnt);
        @(negedge clk);
        div_sel = 8'd0;
        wait_clk(10);
    endtask

    initial begin
        t_reset();
        t_wrap();
        t_latency();
        t_forward();
        t_reverse();
        t_glitch();
        t_index();
        t_error();
        t_divider();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule